// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block places thread blocks of a launched grid onto a set of multiprocessor slots. A request queue upstream presents one block at a time: an identifier and a thread count. The dispatcher offers the block to the processors in a fixed order. It hands the block, whole, to the first processor that still has a free block slot and enough thread headroom. It pops the queue and, one cycle later, reports the chosen processor and the number of 32-thread warps the block occupies.

Each processor keeps three running totals: resident blocks, resident threads and resident warps. A partial last warp counts as a full warp. A completion pulse names a finished block by its identifier. The dispatcher looks up where that block was placed and hands its block slot, threads and warps back to that processor, so a stalled head request can then go ahead. Requests with an impossible size are popped and flagged, and never placed.

Top module: `blk_dispatch`

## Requirements
- R1: A legal request (1 to 512 threads) that fits goes to the lowest-numbered processor where it fits. One cycle after the pop, `disp_valid_o` is high, `disp_sm_o` holds that processor's index and `disp_id_o` holds the request's id.
- R2: No processor ever holds more than 8 resident blocks. A request is never placed on a processor that already holds 8.
- R3: No processor ever holds more than 768 resident threads. A request fits only if the processor's thread total plus its size is at most 768.
- R4: A request of 0 threads or more than 512 threads is popped (`req_ready_o` high). One cycle later `err_o` pulses, `disp_valid_o` stays low and no processor total changes.
- R5: `disp_warps_o` equals ceil(threads/32). The chosen processor's warp total rises by that amount.
- R6: If a legal head request fits nowhere, `req_ready_o` stays low. Nothing is dispatched, and the same request waits until a completion makes room.
- R7: A completion of a resident id lowers that block's processor by one block, by its threads and by its warps, one cycle later. A completion of an id that is not resident changes nothing.
- R8: At most one block is admitted per cycle. `req_ready_o` is low whenever `req_valid_i` is low.
- R9: After reset, all per-processor totals are zero and `disp_valid_o` and `err_o` are low.
- R10: An admission and a completion in the same cycle are both applied. The admission decision uses the totals from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Head of request queue is valid |
| req_id_i | input | ID_W | Block identifier of head request |
| req_thr_i | input | THR_W | Thread count of head request |
| req_ready_o | output | 1 | Head request popped this cycle (placed or rejected) |
| done_valid_i | input | 1 | Completion pulse |
| done_id_i | input | ID_W | Identifier of the finished block |
| disp_valid_o | output | 1 | A block was placed in the previous cycle |
| disp_sm_o | output | SM_W | Processor that received the block |
| disp_id_o | output | ID_W | Identifier of the placed block |
| disp_warps_o | output | DW_W | Warps occupied by the placed block |
| err_o | output | 1 | Previous pop was an illegal-size request |
| sm_blk_o | output | NUM_SM*BLK_W | Resident block count per processor, processor 0 in the low field |
| sm_thr_o | output | NUM_SM*THR_W | Resident thread count per processor |
| sm_wrp_o | output | NUM_SM*WRP_W | Resident warp count per processor |

## Verification
A corrupt per-processor total shows at the count outputs on the cycle after the bad update. The next placement decision is then wrong: it either stalls when it should admit or admits onto a full processor. A stale entry in the placement table shows when that block completes: the wrong processor's totals fall, or none fall. The bench checks all totals after every cycle against an arithmetic model, so either fault appears within one cycle of the stimulus that exposes it.

// File: rtl/blk_dispatch_pkg.sv
package blk_dispatch_pkg;
  // ceil(v / 2**sh)
  function automatic logic [15:0] ceil_shift(input logic [15:0] v, input int unsigned sh);
    logic [15:0] rnd;
    rnd = (16'd1 << sh) - 16'd1;
    return (v + rnd) >> sh;
  endfunction
endpackage

// File: rtl/bd_ledger.sv
module bd_ledger #(
  parameter int unsigned BLK_W = 4,
  parameter int unsigned THR_W = 10,
  parameter int unsigned WRP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic [THR_W-1:0] add_thr_i,
  input  logic [WRP_W-1:0] add_wrp_i,
  input  logic             sub_i,
  input  logic [THR_W-1:0] sub_thr_i,
  input  logic [WRP_W-1:0] sub_wrp_i,
  output logic [BLK_W-1:0] blk_o,
  output logic [THR_W-1:0] thr_o,
  output logic [WRP_W-1:0] wrp_o
);
  logic [BLK_W-1:0] blk_q;
  logic [THR_W-1:0] thr_q;
  logic [WRP_W-1:0] wrp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
      thr_q <= '0;
      wrp_q <= '0;
    end else if (add_i || sub_i) begin
      blk_q <= blk_q + BLK_W'(add_i) - BLK_W'(sub_i);
      thr_q <= thr_q + (add_i ? add_thr_i : '0) - (sub_i ? sub_thr_i : '0);
      wrp_q <= wrp_q + (add_i ? add_wrp_i : '0) - (sub_i ? sub_wrp_i : '0);
    end
  end

  assign blk_o = blk_q;
  assign thr_o = thr_q;
  assign wrp_o = wrp_q;
endmodule

// File: rtl/bd_pick.sv
module bd_pick #(
  parameter int unsigned N    = 4,
  parameter int unsigned SM_W = 2
) (
  input  logic [N-1:0]    fit_i,
  output logic            any_o,
  output logic [SM_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (fit_i[i]) begin
        any_o = 1'b1;
        idx_o = SM_W'(i);
      end
    end
  end
endmodule

// File: rtl/bd_table.sv
module bd_table #(
  parameter int unsigned ID_W  = 6,
  parameter int unsigned SM_W  = 2,
  parameter int unsigned THR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic [SM_W-1:0]  wr_sm_i,
  input  logic [THR_W-1:0] wr_thr_i,
  input  logic             clr_i,
  input  logic [ID_W-1:0]  rd_id_i,
  output logic             rd_hit_o,
  output logic [SM_W-1:0]  rd_sm_o,
  output logic [THR_W-1:0] rd_thr_o
);
  localparam int unsigned DEPTH = 2 ** ID_W;

  logic [DEPTH-1:0] vld_q;
  logic [SM_W-1:0]  sm_q  [DEPTH];
  logic [THR_W-1:0] thr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      if (clr_i) vld_q[rd_id_i] <= 1'b0;
      if (wr_i)  vld_q[wr_id_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      sm_q[wr_id_i]  <= wr_sm_i;
      thr_q[wr_id_i] <= wr_thr_i;
    end
  end

  assign rd_hit_o = vld_q[rd_id_i];
  assign rd_sm_o  = sm_q[rd_id_i];
  assign rd_thr_o = thr_q[rd_id_i];
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
  import blk_dispatch_pkg::*;
#(
  parameter int unsigned NUM_SM  = 4,
  parameter int unsigned BLK_CAP = 8,
  parameter int unsigned THR_CAP = 768,
  parameter int unsigned REQ_MAX = 512,
  parameter int unsigned WARP_SZ = 32,
  parameter int unsigned ID_W    = 6,
  localparam int unsigned SM_W   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  localparam int unsigned THR_W  = $clog2(THR_CAP + 1),
  localparam int unsigned BLK_W  = $clog2(BLK_CAP + 1),
  localparam int unsigned WRP_W  = $clog2(THR_CAP / WARP_SZ + BLK_CAP + 1),
  localparam int unsigned DW_W   = $clog2(REQ_MAX / WARP_SZ + 2)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic [ID_W-1:0]           req_id_i,
  input  logic [THR_W-1:0]          req_thr_i,
  output logic                      req_ready_o,
  input  logic                      done_valid_i,
  input  logic [ID_W-1:0]           done_id_i,
  output logic                      disp_valid_o,
  output logic [SM_W-1:0]           disp_sm_o,
  output logic [ID_W-1:0]           disp_id_o,
  output logic [DW_W-1:0]           disp_warps_o,
  output logic                      err_o,
  output logic [NUM_SM*BLK_W-1:0]   sm_blk_o,
  output logic [NUM_SM*THR_W-1:0]   sm_thr_o,
  output logic [NUM_SM*WRP_W-1:0]   sm_wrp_o
);
  localparam int unsigned WARP_SH = $clog2(WARP_SZ);

  logic              size_ok, any_fit, admit, done_hit;
  logic [NUM_SM-1:0] fit;
  logic [SM_W-1:0]   pick_idx, done_sm;
  logic [THR_W-1:0]  done_thr;
  logic [DW_W-1:0]   req_wrp;
  logic [WRP_W-1:0]  done_wrp;
  logic [BLK_W-1:0]  blk   [NUM_SM];
  logic [THR_W-1:0]  thr   [NUM_SM];
  logic [WRP_W-1:0]  wrp   [NUM_SM];

  assign size_ok  = (req_thr_i != '0) && (req_thr_i <= THR_W'(REQ_MAX));
  assign req_wrp  = DW_W'(ceil_shift(16'(req_thr_i), WARP_SH));
  assign done_wrp = WRP_W'(ceil_shift(16'(done_thr), WARP_SH));

  generate
    for (genvar s = 0; s < NUM_SM; s++) begin : g_sm
      logic [THR_W:0] thr_sum;
      assign thr_sum = {1'b0, thr[s]} + {1'b0, req_thr_i};
      assign fit[s]  = (blk[s] < BLK_W'(BLK_CAP)) && (thr_sum <= (THR_W+1)'(THR_CAP));

      bd_ledger #(.BLK_W(BLK_W), .THR_W(THR_W), .WRP_W(WRP_W)) u_ledger (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .add_i     (admit && (pick_idx == SM_W'(s))),
        .add_thr_i (req_thr_i),
        .add_wrp_i (WRP_W'(req_wrp)),
        .sub_i     (done_hit && (done_sm == SM_W'(s))),
        .sub_thr_i (done_thr),
        .sub_wrp_i (done_wrp),
        .blk_o     (blk[s]),
        .thr_o     (thr[s]),
        .wrp_o     (wrp[s])
      );

      assign sm_blk_o[s*BLK_W +: BLK_W] = blk[s];
      assign sm_thr_o[s*THR_W +: THR_W] = thr[s];
      assign sm_wrp_o[s*WRP_W +: WRP_W] = wrp[s];
    end
  endgenerate

  bd_pick #(.N(NUM_SM), .SM_W(SM_W)) u_pick (
    .fit_i (fit),
    .any_o (any_fit),
    .idx_o (pick_idx)
  );

  logic done_res;
  bd_table #(.ID_W(ID_W), .SM_W(SM_W), .THR_W(THR_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (admit),
    .wr_id_i  (req_id_i),
    .wr_sm_i  (pick_idx),
    .wr_thr_i (req_thr_i),
    .clr_i    (done_hit),
    .rd_id_i  (done_id_i),
    .rd_hit_o (done_res),
    .rd_sm_o  (done_sm),
    .rd_thr_o (done_thr)
  );

  assign done_hit    = done_valid_i && done_res;
  assign admit       = req_valid_i && size_ok && any_fit;
  assign req_ready_o = req_valid_i && (!size_ok || any_fit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_valid_o <= 1'b0;
      disp_sm_o    <= '0;
      disp_id_o    <= '0;
      disp_warps_o <= '0;
      err_o        <= 1'b0;
    end else begin
      disp_valid_o <= admit;
      err_o        <= req_valid_i && !size_ok;
      if (admit) begin
        disp_sm_o    <= pick_idx;
        disp_id_o    <= req_id_i;
        disp_warps_o <= req_wrp;
      end
    end
  end
endmodule

// File: rtl/bd_chk.sv
module bd_chk #(
  parameter int unsigned NUM_SM  = 4,
  parameter int unsigned BLK_CAP = 8,
  parameter int unsigned THR_CAP = 768,
  parameter int unsigned REQ_MAX = 512,
  parameter int unsigned WARP_SZ = 32,
  parameter int unsigned ID_W    = 6,
  localparam int unsigned THR_W  = $clog2(THR_CAP + 1),
  localparam int unsigned BLK_W  = $clog2(BLK_CAP + 1),
  localparam int unsigned WRP_W  = $clog2(THR_CAP / WARP_SZ + BLK_CAP + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic [ID_W-1:0]         req_id_i,
  input logic [THR_W-1:0]        req_thr_i,
  input logic                    req_ready_o,
  input logic                    disp_valid_o,
  input logic [ID_W-1:0]         disp_id_o,
  input logic                    err_o,
  input logic [NUM_SM*BLK_W-1:0] sm_blk_o,
  input logic [NUM_SM*THR_W-1:0] sm_thr_o,
  input logic [NUM_SM*WRP_W-1:0] sm_wrp_o
);
  logic legal;
  assign legal = (req_thr_i != '0) && (req_thr_i <= THR_W'(REQ_MAX));

  generate
    for (genvar s = 0; s < NUM_SM; s++) begin : g_c
      p_blk_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(sm_blk_o[s*BLK_W +: BLK_W]) <= int'(BLK_CAP));
      p_thr_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(sm_thr_o[s*THR_W +: THR_W]) <= int'(THR_CAP));
      p_warp_span_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(sm_wrp_o[s*WRP_W +: WRP_W]) * int'(WARP_SZ) >= int'(sm_thr_o[s*THR_W +: THR_W])) &&
        (int'(sm_wrp_o[s*WRP_W +: WRP_W]) <= int'(sm_thr_o[s*THR_W +: THR_W])));
    end
  endgenerate

  p_admit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && legal) |=> (disp_valid_o && disp_id_o == $past(req_id_i)));
  p_reject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !legal) |=> (err_o && !disp_valid_o));
  p_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> (!disp_valid_o && !err_o));
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !req_ready_o);
endmodule

bind blk_dispatch bd_chk #(
  .NUM_SM(NUM_SM), .BLK_CAP(BLK_CAP), .THR_CAP(THR_CAP),
  .REQ_MAX(REQ_MAX), .WARP_SZ(WARP_SZ), .ID_W(ID_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_id_i(req_id_i),
  .req_thr_i(req_thr_i), .req_ready_o(req_ready_o), .disp_valid_o(disp_valid_o),
  .disp_id_o(disp_id_o), .err_o(err_o), .sm_blk_o(sm_blk_o), .sm_thr_o(sm_thr_o),
  .sm_wrp_o(sm_wrp_o)
);

// File: tb/sim_blk_dispatch.sv
`timescale 1ns/1ps
module sim_blk_dispatch;
  localparam int NSM = 4, BW = 4, TW = 10, WW = 6, IW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_v = 1'b0, done_v = 1'b0;
  logic [IW-1:0] req_id = '0, done_id = '0;
  logic [TW-1:0] req_thr = '0;
  logic ready, dv, err;
  logic [1:0] dsm;
  logic [IW-1:0] did;
  logic [4:0] dwarps;
  logic [NSM*BW-1:0] blk;
  logic [NSM*TW-1:0] thr;
  logic [NSM*WW-1:0] wrp;

  always #5 clk = ~clk;

  blk_dispatch u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_id_i(req_id),
    .req_thr_i(req_thr), .req_ready_o(ready), .done_valid_i(done_v),
    .done_id_i(done_id), .disp_valid_o(dv), .disp_sm_o(dsm), .disp_id_o(did),
    .disp_warps_o(dwarps), .err_o(err), .sm_blk_o(blk), .sm_thr_o(thr), .sm_wrp_o(wrp)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int m_blk [NSM], m_thr [NSM], m_wrp [NSM];
  bit m_vld [64];
  int m_sm [64], m_t [64];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic chk_totals(input string rq);
    for (int s = 0; s < NSM; s++) begin
      chk(int'(blk[s*BW +: BW]) == m_blk[s], rq, int'(blk[s*BW +: BW]), m_blk[s]);
      chk(int'(thr[s*TW +: TW]) == m_thr[s], rq, int'(thr[s*TW +: TW]), m_thr[s]);
      chk(int'(wrp[s*WW +: WW]) == m_wrp[s], rq, int'(wrp[s*WW +: WW]), m_wrp[s]);
    end
  endtask

  // one cycle: optional request and optional completion
  task automatic step(input bit rv, input int id, input int t, input bit cv, input int cid, input string rq);
    bit ok_sz, exp_rdy;
    int pick;
    @(negedge clk);
    req_v = rv; req_id = IW'(id); req_thr = TW'(t);
    done_v = cv; done_id = IW'(cid);
    #1;
    ok_sz = (t >= 1) && (t <= 512);
    pick = -1;
    if (ok_sz)
      for (int s = NSM - 1; s >= 0; s--)
        if (m_blk[s] < 8 && m_thr[s] + t <= 768) pick = s;
    exp_rdy = rv && (!ok_sz || pick >= 0);
    chk(ready == exp_rdy, (rv && ok_sz && pick < 0) ? "R6" : "R8", int'(ready), int'(exp_rdy));
    @(posedge clk);
    #1;
    req_v = 1'b0; done_v = 1'b0;
    chk(dv == (rv && ok_sz && pick >= 0), "R1", int'(dv), int'(rv && ok_sz && pick >= 0));
    chk(err == (rv && !ok_sz), "R4", int'(err), int'(rv && !ok_sz));
    if (rv && ok_sz && pick >= 0) begin
      chk(int'(dsm) == pick, "R1", int'(dsm), pick);
      chk(int'(did) == id, "R1", int'(did), id);
      chk(int'(dwarps) == (t + 31) / 32, "R5", int'(dwarps), (t + 31) / 32);
    end
    if (cv && m_vld[cid]) begin
      m_vld[cid] = 0;
      m_blk[m_sm[cid]] -= 1;
      m_thr[m_sm[cid]] -= m_t[cid];
      m_wrp[m_sm[cid]] -= (m_t[cid] + 31) / 32;
    end
    if (rv && ok_sz && pick >= 0) begin
      m_vld[id] = 1; m_sm[id] = pick; m_t[id] = t;
      m_blk[pick] += 1; m_thr[pick] += t; m_wrp[pick] += (t + 31) / 32;
    end
    chk_totals(rq);
  endtask

  function automatic int free_id(input int start);
    for (int k = 0; k < 64; k++)
      if (!m_vld[(start + k) % 64]) return (start + k) % 64;
    return 0;
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int nid;
    for (int s = 0; s < NSM; s++) begin m_blk[s] = 0; m_thr[s] = 0; m_wrp[s] = 0; end
    for (int i = 0; i < 64; i++) begin m_vld[i] = 0; m_sm[i] = 0; m_t[i] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R9 reset state
    #1;
    chk(dv == 1'b0, "R9", int'(dv), 0);
    chk(err == 1'b0, "R9", int'(err), 0);
    chk_totals("R9");
    step(0, 0, 0, 0, 0, "R8");

    // size sweep: R4 rejects, R5 warp rounding, R7 release
    for (int t = 0; t <= 600; t++) begin
      step(1, 1, t, 0, 0, "R4");
      step(0, 0, 0, 1, 1, "R7");
    end

    // R3: 256-thread blocks fill three per processor
    for (int i = 0; i < 12; i++) step(1, i, 256, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(1, 20, 256, 0, 0, "R6");
    step(0, 0, 0, 1, 4, "R7");           // block 4 sits on processor 1
    step(1, 20, 256, 0, 0, "R1");
    step(1, 21, 1, 0, 0, "R6");
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1, i, "R7");
    step(0, 0, 0, 1, 20, "R7");

    // R2: small blocks hit the block cap before the thread cap
    for (int i = 0; i < 32; i++) step(1, i, 16, 0, 0, "R2");
    step(1, 40, 16, 0, 0, "R6");
    step(0, 0, 0, 1, 50, "R7");          // not resident: ignored
    step(0, 0, 0, 1, 17, "R7");          // processor 2 frees a slot
    step(1, 40, 16, 0, 0, "R2");
    // R10: completion and admission in one cycle, decided on old totals
    step(1, 41, 16, 1, 0, "R10");
    step(1, 41, 16, 0, 0, "R10");
    for (int i = 0; i < 64; i++) step(0, 0, 0, 1, i, "R7");

    // R10 mixed walk
    lfsr = 16'hACE1;
    nid = 0;
    for (int n = 0; n < 3000; n++) begin
      int t, cid;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      t = (int'(lfsr) % 520);
      cid = int'(lfsr[11:6]);
      nid = free_id(nid + 1);
      step(lfsr[0] | lfsr[3], nid, t, lfsr[1] & lfsr[4], cid, "R10");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule